// File: doc/BRIEF.md
# Shared-Interval Input Deglitch Filter

This block cleans a bank of asynchronous digital inputs before later logic reads them or looks for edges on them. Every input goes through a two-flop synchroniser. Each channel then either passes the synchronised level straight to its output or sends it through a stability filter. A filtered output moves to a new level only after the input has held that level for a programmed number of 200 ns ticks. The tick comes from a prescaler that divides the system clock, and the division ratio is set from the clock frequency parameter.

All channels share one interval register. Filtering is switched on or off for each bit through one enable byte per 8-bit port. A small byte/word register interface programs the interval and the enables and reads them back. There is no data stream at the block edge. The inputs are sampled levels and the outputs are levels, so there is no valid/ready handshake and no back-pressure.

Top module: `deglitch_bank`

## Requirements
- R1: The filter time base is one tick per 200 ns. The tick is derived from the CLK_HZ parameter, which gives 10 clock cycles per tick at 50 MHz. With an interval of 1, a filtered channel still holds its old level in the cycle its synchronised input changes, and takes the new level within one tick period after that.
- R2: The interval register is at address 0x08. A word write (bus_word=1) loads bus_wdata[19:0] and drops the upper bits, so the largest value is 0xFFFFF. A read returns the interval zero-extended to 32 bits. A byte write to 0x08 leaves the interval unchanged.
- R3: Port p has its filter enable byte at address 0x44 + 0x10*p. It is loaded by a byte write (bus_word=0) from bus_wdata[7:0] and read back in bus_rdata[7:0]. Bit b of that byte enables filtering on channel 8*p+b.
- R4: Take a channel whose enable bit is set and whose interval N is nonzero. Its output takes a new level only after the synchronised input has held that level continuously through N ticks. Any shorter pulse never reaches the output. The output changes only in the cycle after a tick.
- R5: A channel whose enable bit is clear, or any channel while the interval is zero, drives dout with its input delayed by exactly the two synchroniser cycles.
- R6: After reset the interval and every enable byte read as zero, and dout is zero.
- R7: Any word write to the interval register restarts the stability count of every filtered channel. A change in progress then needs N full ticks counted from after the write.
- R8: Changing one channel's enable bit, or writing one port's enable byte, leaves the enables of all other channels and ports unchanged, and those channels keep filtering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_word | input | 1 | 1 = 32-bit write, 0 = byte write |
| bus_addr | input | 8 | Write address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 8 | Read address |
| bus_rdata | output | 32 | Read data for bus_raddr, unmapped addresses read zero |
| din | input | 8*NUM_PORTS | Asynchronous raw inputs |
| dout | output | 8*NUM_PORTS | Deglitched outputs |

## Verification
The hardest case to reach from the ports is a rewrite of the interval while a channel is partway through a stable period. The bench raises one filtered input and rewrites the same interval value halfway through the count. It then checks that the output is still at the old level at a time when an unrestarted count would already have finished, and that the new level arrives later. Glitch suppression is checked by holding a pulse for fewer cycles than N ticks can ever fit. Per-bit isolation is checked by clearing a single enable bit and sending a glitch on a neighbouring bit in the same port.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned IVL_W       = 20;
  localparam logic [7:0]  IVL_ADDR    = 8'h08;
  localparam int unsigned PORT_BASE   = 'h40;
  localparam int unsigned PORT_STRIDE = 'h10;
  localparam int unsigned EN_OFS      = 'h4;

  function automatic logic [ADDR_W-1:0] en_addr(input int unsigned p);
    int unsigned a;
    a = PORT_BASE + PORT_STRIDE * p + EN_OFS;
    return a[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/dgf_tick.sv
module dgf_tick #(
  parameter int unsigned DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = rst_n;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == CW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/dgf_regs.sv
module dgf_regs
  import deglitch_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic                   bus_word,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  input  logic [ADDR_W-1:0]      bus_raddr,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic [IVL_W-1:0]       ivl,
  output logic [8*NUM_PORTS-1:0] en,
  output logic                   restart
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl     <= '0;
      restart <= 1'b0;
    end else begin
      restart <= 1'b0;
      if (bus_we && bus_word && bus_addr == IVL_ADDR) begin
        ivl     <= bus_wdata[IVL_W-1:0];
        restart <= 1'b1;
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_en
    always_ff @(posedge clk) begin
      if (!rst_n) en[8*p +: 8] <= 8'h00;
      else if (bus_we && !bus_word && bus_addr == en_addr(p))
        en[8*p +: 8] <= bus_wdata[7:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_raddr == IVL_ADDR) bus_rdata = DATA_W'(ivl);
    for (int p = 0; p < NUM_PORTS; p++)
      if (bus_raddr == en_addr(p)) bus_rdata = DATA_W'(en[8*p +: 8]);
  end
endmodule

// File: rtl/dgf_chan.sv
module dgf_chan
  import deglitch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic             en,
  input  logic [IVL_W-1:0] ivl,
  input  logic             tick,
  input  logic             restart,
  output logic             level
);
  logic             s1_q, s2_q, held_q;
  logic [IVL_W-1:0] cnt_q;
  logic             bypass;
  logic [IVL_W:0]   next_cnt;

  assign bypass   = !en || (ivl == '0);
  assign next_cnt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      cnt_q  <= '0;
    end else if (bypass) begin
      held_q <= s2_q;
      cnt_q  <= '0;
    end else if (restart || s2_q == held_q) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (next_cnt >= {1'b0, ivl}) begin
        held_q <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= next_cnt[IVL_W-1:0];
      end
    end
  end

  assign level = bypass ? s2_q : held_q;
endmodule

// File: rtl/deglitch_bank.sv
module deglitch_bank
  import deglitch_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned TICK_NS   = 200
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic                   bus_word,
  input  logic [7:0]             bus_addr,
  input  logic [31:0]            bus_wdata,
  input  logic [7:0]             bus_raddr,
  output logic [31:0]            bus_rdata,
  input  logic [8*NUM_PORTS-1:0] din,
  output logic [8*NUM_PORTS-1:0] dout
);
  localparam int unsigned NCH      = 8 * NUM_PORTS;
  localparam int unsigned RAW_DIV  = (CLK_HZ / 1000) * TICK_NS / 1_000_000;
  localparam int unsigned TICK_DIV = (RAW_DIV < 1) ? 1 : RAW_DIV;

  logic             tick_w;
  logic             restart_w;
  logic [IVL_W-1:0] ivl_w;
  logic [NCH-1:0]   en_w;

  dgf_tick #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_w)
  );

  dgf_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_word (bus_word),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_raddr(bus_raddr),
    .bus_rdata(bus_rdata),
    .ivl      (ivl_w),
    .en       (en_w),
    .restart  (restart_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dgf_chan u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (din[c]),
      .en     (en_w[c]),
      .ivl    (ivl_w),
      .tick   (tick_w),
      .restart(restart_w),
      .level  (dout[c])
    );
  end
endmodule

// File: rtl/deglitch_bank_chk.sv
module deglitch_bank_chk
  import deglitch_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_we,
  input logic                   bus_word,
  input logic [7:0]             bus_addr,
  input logic [31:0]            bus_wdata,
  input logic [8*NUM_PORTS-1:0] din,
  input logic [8*NUM_PORTS-1:0] dout,
  input logic                   tick_w,
  input logic [IVL_W-1:0]       ivl_w,
  input logic [8*NUM_PORTS-1:0] en_w
);
  localparam int unsigned NCH = 8 * NUM_PORTS;

  logic [NCH-1:0] byp;
  logic [1:0]     age_q;
  logic           in_rst_q;

  assign byp = ~en_w | {NCH{ivl_w == '0}};

  always_ff @(posedge clk) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    in_rst_q <= !rst_n;
    if (rst_n && in_rst_q)
      assert_reset_state_R6: assert (ivl_w == '0 && en_w == '0);
  end

  assert_ivl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_word && bus_addr == IVL_ADDR) |=> ivl_w == $past(bus_wdata[IVL_W-1:0]));

  assert_ivl_byte_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_word) |=> $stable(ivl_w));

  assert_change_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(en_w) && $stable(ivl_w) && ivl_w != '0 && !$past(tick_w))
      |-> (((dout ^ $past(dout)) & en_w) == '0));

  assert_bypass_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (((dout ^ $past(din, 2)) & byp) == '0));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_iso
    assert_port_isolation_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && !bus_word && bus_addr == en_addr(p)) |=> $stable(en_w[8*p +: 8]));
  end
endmodule

bind deglitch_bank deglitch_bank_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_word (bus_word),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .din      (din),
  .dout     (dout),
  .tick_w   (tick_w),
  .ivl_w    (ivl_w),
  .en_w     (en_w)
);

// File: tb/deglitch_bank_tb.sv
module deglitch_bank_tb;
  localparam int NP  = 4;
  localparam int NCH = 8 * NP;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_we = 1'b0;
  logic           bus_word = 1'b0;
  logic [7:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [7:0]     bus_raddr = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] din = '0;
  logic [NCH-1:0] dout;

  int  cyc = 0;
  int  n_tests = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  typedef struct {
    int             due;
    logic [NCH-1:0] exp;
    string          req;
  } exp_t;
  exp_t sbq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  deglitch_bank #(.NUM_PORTS(NP), .CLK_HZ(50_000_000)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_raddr(bus_raddr),
    .bus_rdata(bus_rdata), .din(din), .dout(dout)
  );

  task automatic push(input int due, input logic [NCH-1:0] e, input string req);
    exp_t it;
    it.due = due; it.exp = e; it.req = req;
    sbq.push_back(it);
  endtask

  // monitor: pops expectations when their cycle arrives
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due == cyc) begin
        n_tests++;
        if (dout !== sbq[i].exp) begin
          n_fail++;
          $display("FAIL %s cycle %0d dout actual %h expected %h", sbq[i].req, cyc, dout, sbq[i].exp);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic word);
    @(negedge clk);
    bus_we = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk_read(input logic [7:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    bus_raddr = a;
    #1;
    n_tests++;
    if (bus_rdata !== e) begin
      n_fail++;
      $display("FAIL %s read %h actual %h expected %h", req, a, bus_rdata, e);
    end
  endtask

  task automatic set_din(input logic [NCH-1:0] v, output int at);
    @(negedge clk);
    din = v;
    at = cyc;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    int c;
    wait_cyc(4);
    rst_n = 1'b1;
    // R6: reset state
    chk_read(8'h08, 32'h0, "R6");
    chk_read(8'h44, 32'h0, "R6");
    chk_read(8'h74, 32'h0, "R6");
    n_tests++;
    if (dout !== '0) begin
      n_fail++;
      $display("FAIL R6 dout actual %h expected 0", dout);
    end

    // R5: enables clear -> two-cycle passthrough
    set_din(32'h0000_00A5, c); push(c + 3, 32'h0000_00A5, "R5");
    wait_cyc(5);
    set_din(32'h0, c); push(c + 3, 32'h0, "R5");
    wait_cyc(5);

    // R2: interval register width and byte-write immunity
    bus_write(8'h08, 32'hFFFF_FFFF, 1'b1);
    chk_read(8'h08, 32'h000F_FFFF, "R2");
    bus_write(8'h08, 32'h0, 1'b0);
    chk_read(8'h08, 32'h000F_FFFF, "R2");
    bus_write(8'h08, 32'd3, 1'b1);
    chk_read(8'h08, 32'd3, "R2");

    // R3 / R8: per-port enable bytes
    bus_write(8'h44, 32'hFF, 1'b0);
    bus_write(8'h54, 32'h0F, 1'b0);
    chk_read(8'h44, 32'hFF, "R3");
    chk_read(8'h54, 32'h0F, "R3");
    chk_read(8'h64, 32'h00, "R8");
    wait_cyc(10);

    // R4: long level passes after 3 ticks
    set_din(32'h1, c);
    push(c + 20, 32'h0, "R4"); push(c + 36, 32'h1, "R4");
    wait_cyc(40);

    // R4: 15-cycle glitch on bit1 is suppressed
    set_din(32'h3, c);
    push(c + 10, 32'h1, "R4"); push(c + 25, 32'h1, "R4"); push(c + 45, 32'h1, "R4");
    wait_cyc(14);
    din = 32'h1;
    wait_cyc(40);

    // R7: rewriting interval mid-count restarts the count
    set_din(32'h5, c);
    push(c + 35, 32'h1, "R7"); push(c + 55, 32'h5, "R7");
    wait_cyc(14);
    bus_write(8'h08, 32'd3, 1'b1);
    wait_cyc(50);

    // R8: clear a single bit; neighbours keep filtering
    bus_write(8'h44, 32'hF7, 1'b0);
    chk_read(8'h44, 32'hF7, "R8");
    chk_read(8'h54, 32'h0F, "R8");
    set_din(32'hD, c); push(c + 3, 32'hD, "R8");
    wait_cyc(5);
    set_din(32'h111D, c);
    push(c + 5, 32'h100D, "R8"); push(c + 13, 32'hD, "R8"); push(c + 30, 32'hD, "R8");
    wait_cyc(10);
    din = 32'hD;
    wait_cyc(40);

    // R1: interval of one tick
    bus_write(8'h08, 32'd1, 1'b1);
    wait_cyc(5);
    set_din(32'h2D, c);
    push(c + 2, 32'hD, "R1"); push(c + 13, 32'h2D, "R1");
    wait_cyc(20);

    // R5: zero interval bypasses all channels
    bus_write(8'h08, 32'd0, 1'b1);
    chk_read(8'h08, 32'h0, "R5");
    set_din(32'h6D, c); push(c + 3, 32'h6D, "R5");
    wait_cyc(4);
    set_din(32'h2D, c); push(c + 3, 32'h2D, "R5");
    wait_cyc(10);

    while (sbq.size() != 0) wait_cyc(1);
    finish_run();
  end
endmodule